// File: doc/BRIEF.md
# Legacy System Control Port Unit

This block sits on an 8-bit I/O bus and answers four legacy PC port addresses. Port 70h holds the index of a real-time-clock / CMOS RAM location. Port 71h is the data window onto that location: the block passes reads and writes through to an external RTC interface, using the stored index as the address. A sticky protection lock can close the CMOS window 38h–3Fh to every access.

Port 92h is the system control port. It holds a fast CPU reset bit, a fast A20 gate bit and the lock bit. Writes to F0h or F1h clear a latched coprocessor error, and that latch drives IRQ13.

All bus accesses are single-cycle strobes. Read data is combinational while the read strobe is high. Register updates take effect at the clock edge that ends the access.

Top module: `sysctl_port_unit`

## Requirements
- R1: A write to 70h stores the full 8-bit data as the RTC index, which appears on `rtc_idx` from the next cycle. A read of 71h raises `rtc_rd` in the same cycle and returns `rtc_rdata` on `io_rdata`. A write of 71h raises `rtc_wr` with `rtc_wdata` equal to the bus data.
- R2: A write to 92h stores data bit 0 as the reset bit. When that bit goes from 0 to 1, `cpu_rst_pulse` is high for exactly one cycle, in the cycle after the write. Writing 1 while the bit is already 1 gives no pulse. Writing 0 and then 1 gives a new pulse.
- R3: `a20_gate` equals `a20_ext` OR the stored 92h bit 1. A write to 92h stores data bit 1.
- R4: While `lock_allow` is 0, writing 1 to 92h bit 5 has no effect. Bit 5 keeps reading 0, and CMOS 38h–3Fh stays accessible.
- R5: A write of 92h with bit 5 = 1 while `lock_allow` is 1 sets the lock. Once set, the lock reads 1 in bit 5, and later writes of 0 do not clear it. Only `rst_n` clears it.
- R6: While the lock is set and the index is in 38h–3Fh, a 71h read returns FFh and does not raise `rtc_rd`. A 71h write in the same condition does not raise `rtc_wr`. Indices outside that range behave as in R1.
- R7: A read of 92h returns bit 0 = reset bit, bit 1 = A20 bit and bit 5 = lock. All other bits read 0.
- R8: A pulse on `fpu_err` sets the error latch, and `irq13` is high from the next cycle. A write to F0h or F1h, with any data, clears it from the next cycle. A set and a clear in the same cycle leave it set.
- R9: After reset, the index, the 92h bits, the lock and the error latch are all 0. `cpu_rst_pulse` is 0 and `a20_gate` follows `a20_ext`.
- R10: A read of any other port address returns 00h and leaves `io_hit` low. `io_hit` is high for a read or write of 70h, 71h, 92h, F0h or F1h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| io_hit | output | 1 | Access targets a decoded port |
| lock_allow | input | 1 | Configuration bit that permits setting the lock |
| rtc_idx | output | 8 | Current RTC/CMOS index |
| rtc_rd | output | 1 | Read strobe to the RTC interface |
| rtc_wr | output | 1 | Write strobe to the RTC interface |
| rtc_wdata | output | 8 | Write data to the RTC interface |
| rtc_rdata | input | 8 | Read data from the RTC interface |
| a20_ext | input | 1 | OR of the other A20 gate sources |
| a20_gate | output | 1 | A20 gate; high leaves A20 unmasked |
| cpu_rst_pulse | output | 1 | One-cycle fast CPU reset request |
| fpu_err | input | 1 | Coprocessor error set strobe |
| irq13 | output | 1 | Coprocessor error interrupt |

## Verification
The hardest situation to reach is the lock. It needs `lock_allow` high in the same cycle as a 92h write with bit 5 set, and only then does the 38h–3Fh index window act differently. Random traffic would almost never do both in order.

The bench therefore walks a directed path:
- first it shows the bit ignored with `lock_allow` low;
- then it sets the lock and probes both window edges (37h, 38h, 3Fh, 40h);
- then it tries to clear the lock.

After that, random operations run from an index pool biased toward the window, with the lock already set. A second reset then confirms that only reset releases the lock.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW = 8;

  // true when idx lies in the protected CMOS window [lo, hi]
  function automatic logic in_window(input logic [DW-1:0] idx,
                                     input logic [DW-1:0] lo,
                                     input logic [DW-1:0] hi);
    return (idx >= lo) && (idx <= hi);
  endfunction

  // readback image of the system control port
  function automatic logic [DW-1:0] pack_ctrl(input logic rst_b,
                                              input logic a20_b,
                                              input logic lock_b);
    logic [DW-1:0] v;
    v    = '0;
    v[0] = rst_b;
    v[1] = a20_b;
    v[5] = lock_b;
    return v;
  endfunction
endpackage

// File: rtl/rtc_gate.sv
module rtc_gate
  import sysctl_pkg::*;
#(
  parameter logic [DW-1:0] WIN_LO = 8'h38,
  parameter logic [DW-1:0] WIN_HI = 8'h3F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic [DW-1:0] wdata,
  input  logic          dat_rd,
  input  logic          dat_wr,
  input  logic          lock,
  output logic [DW-1:0] rtc_idx,
  output logic          rtc_rd,
  output logic          rtc_wr,
  output logic          blocked
);
  logic [DW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      idx_q <= '0;
    else if (idx_wr) idx_q <= wdata;

  assign rtc_idx = idx_q;
  assign blocked = lock && in_window(idx_q, WIN_LO, WIN_HI);
  assign rtc_rd  = dat_rd && !blocked;
  assign rtc_wr  = dat_wr && !blocked;

  // R6
  no_blocked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && idx_q >= WIN_LO && idx_q <= WIN_HI) |-> !rtc_wr && !rtc_rd);
  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(rtc_idx));
endmodule

// File: rtl/ctrl_port92.sv
module ctrl_port92
  import sysctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          d_rst,
  input  logic          d_a20,
  input  logic          d_lock,
  input  logic          lock_allow,
  input  logic          a20_ext,
  output logic          lock,
  output logic          a20_gate,
  output logic          cpu_rst_pulse,
  output logic [DW-1:0] rd_val
);
  logic rst_q, a20_q, lock_q, pulse_q;
  logic rst_rise, lock_set;

  assign rst_rise = wr && d_rst && !rst_q;
  assign lock_set = wr && d_lock && lock_allow;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_q <= 1'b0; a20_q <= 1'b0; lock_q <= 1'b0; pulse_q <= 1'b0;
    end else begin
      pulse_q <= rst_rise;
      if (wr) begin
        rst_q <= d_rst;
        a20_q <= d_a20;
      end
      if (lock_set) lock_q <= 1'b1;
    end

  assign lock          = lock_q;
  assign a20_gate      = a20_ext | a20_q;
  assign cpu_rst_pulse = pulse_q;
  assign rd_val        = pack_ctrl(rst_q, a20_q, lock_q);

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R4
  lock_needs_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && !lock_allow) |=> !lock_q);
  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_pulse |=> !cpu_rst_pulse);
  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_pulse |-> rst_q && !$past(rst_q));
endmodule

// File: rtl/coproc_err.sv
module coproc_err (
  input  logic clk,
  input  logic rst_n,
  input  logic err_set,
  input  logic err_clr,
  output logic irq13
);
  logic err_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;

  assign irq13 = err_q;

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> irq13);
  // R8
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !err_set) |=> !irq13);
endmodule

// File: rtl/sysctl_port_unit.sv
module sysctl_port_unit
  import sysctl_pkg::*;
#(
  parameter logic [7:0] PORT_IDX = 8'h70,
  parameter logic [7:0] PORT_DAT = 8'h71,
  parameter logic [7:0] PORT_SYS = 8'h92,
  parameter logic [7:0] PORT_ERR = 8'hF0,
  parameter logic [7:0] WIN_LO   = 8'h38,
  parameter logic [7:0] WIN_HI   = 8'h3F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] io_addr,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       io_hit,
  input  logic       lock_allow,
  output logic [7:0] rtc_idx,
  output logic       rtc_rd,
  output logic       rtc_wr,
  output logic [7:0] rtc_wdata,
  input  logic [7:0] rtc_rdata,
  input  logic       a20_ext,
  output logic       a20_gate,
  output logic       cpu_rst_pulse,
  input  logic       fpu_err,
  output logic       irq13
);
  localparam logic [DW-1:0] BLOCK_VAL = '1;

  logic sel_idx, sel_dat, sel_sys, sel_err, acc;
  logic lock, blocked;
  logic [DW-1:0] sys_val;

  assign acc     = io_wr || io_rd;
  assign sel_idx = io_addr == PORT_IDX;
  assign sel_dat = io_addr == PORT_DAT;
  assign sel_sys = io_addr == PORT_SYS;
  assign sel_err = io_addr[7:1] == PORT_ERR[7:1];
  assign io_hit  = acc && (sel_idx || sel_dat || sel_sys || sel_err);

  rtc_gate #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_rtc (
    .clk(clk), .rst_n(rst_n),
    .idx_wr(io_wr && sel_idx), .wdata(io_wdata),
    .dat_rd(io_rd && sel_dat), .dat_wr(io_wr && sel_dat),
    .lock(lock), .rtc_idx(rtc_idx), .rtc_rd(rtc_rd), .rtc_wr(rtc_wr),
    .blocked(blocked));

  assign rtc_wdata = io_wdata;

  ctrl_port92 u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(io_wr && sel_sys),
    .d_rst(io_wdata[0]), .d_a20(io_wdata[1]), .d_lock(io_wdata[5]),
    .lock_allow(lock_allow), .a20_ext(a20_ext), .lock(lock),
    .a20_gate(a20_gate), .cpu_rst_pulse(cpu_rst_pulse), .rd_val(sys_val));

  coproc_err u_err (
    .clk(clk), .rst_n(rst_n), .err_set(fpu_err),
    .err_clr(io_wr && sel_err), .irq13(irq13));

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (sel_idx)      io_rdata = rtc_idx;
      else if (sel_dat) io_rdata = blocked ? BLOCK_VAL : rtc_rdata;
      else if (sel_sys) io_rdata = sys_val;
    end
  end

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_hit) |-> io_rdata == 8'h00);
  // R3
  a20_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a20_ext |-> a20_gate);
endmodule

// File: tb/tb_sysctl_port_unit.sv
module tb_sysctl_port_unit;
  logic clk = 0, rst_n = 0;
  logic [7:0] io_addr = 0, io_wdata = 0, rtc_rdata = 0;
  logic io_wr = 0, io_rd = 0, lock_allow = 0, a20_ext = 0, fpu_err = 0;
  logic [7:0] io_rdata, rtc_idx, rtc_wdata;
  logic io_hit, rtc_rd, rtc_wr, a20_gate, cpu_rst_pulse, irq13;

  int checks = 0, fails = 0;
  logic [7:0] m_idx;
  logic m_rst, m_a20, m_lock, m_err, m_pulse;

  always #2 clk = ~clk;

  sysctl_port_unit dut (.*);

  function automatic logic prot(input logic [7:0] i);
    return i inside {[8'h38:8'h3F]};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a, input logic [7:0] rd_in);
    if (a == 8'h70) return m_idx;
    if (a == 8'h71) return (m_lock && prot(m_idx)) ? 8'hFF : rd_in;
    if (a == 8'h92) return {2'b00, m_lock, 3'b000, m_a20, m_rst};
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mreset();
    m_idx = 0; m_rst = 0; m_a20 = 0; m_lock = 0; m_err = 0; m_pulse = 0;
  endtask

  // one bus cycle: drive after negedge, check combinational outputs, update model at posedge
  task automatic op(input logic w, input logic r, input logic [7:0] a,
                    input logic [7:0] d, input logic la, input logic ext,
                    input logic fe);
    logic hit, blk;
    @(negedge clk);
    io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
    lock_allow = la; a20_ext = ext; fpu_err = fe; rtc_rdata = 8'($urandom);
    #1;
    hit = (w || r) && (a inside {8'h70, 8'h71, 8'h92, 8'hF0, 8'hF1});
    blk = m_lock && prot(m_idx);
    chk("R10 io_hit", io_hit, hit);
    chk("R9/R2 cpu_rst_pulse", cpu_rst_pulse, m_pulse);
    chk("R3 a20_gate", a20_gate, ext | m_a20);
    chk("R8 irq13", irq13, m_err);
    chk("R1 rtc_idx", rtc_idx, m_idx);
    chk("R6/R1 rtc_rd", rtc_rd, r && a == 8'h71 && !blk);
    chk("R6/R1 rtc_wr", rtc_wr, w && a == 8'h71 && !blk);
    if (w && a == 8'h71 && !blk) chk("R1 rtc_wdata", rtc_wdata, d);
    if (r) chk("R7/R6/R10 io_rdata", io_rdata, exp_rd(a, rtc_rdata));
    @(posedge clk);
    m_pulse = 0;
    if (w && a == 8'h70) m_idx = d;
    if (w && a == 8'h92) begin
      m_pulse = d[0] && !m_rst;
      m_rst = d[0]; m_a20 = d[1];
      if (la && d[5]) m_lock = 1;
    end
    if (fe) m_err = 1;
    else if (w && (a == 8'hF0 || a == 8'hF1)) m_err = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    io_wr = 0; io_rd = 0; fpu_err = 0;
    rst_n = 0; #1; mreset();
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    mreset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    op(0, 1, 8'h92, 0, 0, 0, 0);
    op(0, 1, 8'h70, 0, 0, 1, 0);
    // R1 index and data path
    op(1, 0, 8'h70, 8'h0A, 0, 0, 0);
    op(0, 1, 8'h71, 0, 0, 0, 0);
    op(1, 0, 8'h71, 8'h5C, 0, 0, 0);
    // R2 edge pulse, repeat write, re-arm
    op(1, 0, 8'h92, 8'h01, 0, 0, 0);
    op(1, 0, 8'h92, 8'h01, 0, 0, 0);
    op(1, 0, 8'h92, 8'h00, 0, 0, 0);
    op(1, 0, 8'h92, 8'h03, 0, 0, 0);
    op(0, 1, 8'h92, 0, 0, 0, 0);
    // R7 reserved bits ignored
    op(1, 0, 8'h92, 8'hDC, 0, 0, 0);
    op(0, 1, 8'h92, 0, 0, 0, 0);
    // R4 lock write ignored without permission
    op(1, 0, 8'h92, 8'h20, 0, 0, 0);
    op(0, 1, 8'h92, 0, 0, 0, 0);
    op(1, 0, 8'h70, 8'h3A, 0, 0, 0);
    op(0, 1, 8'h71, 0, 0, 0, 0);
    // R5 set lock, try to clear
    op(1, 0, 8'h92, 8'h20, 1, 0, 0);
    op(1, 0, 8'h92, 8'h00, 1, 0, 0);
    op(0, 1, 8'h92, 0, 0, 0, 0);
    // R6 window edges
    for (int k = 0; k < 4; k++) begin
      logic [7:0] ix;
      ix = (k == 0) ? 8'h37 : (k == 1) ? 8'h38 : (k == 2) ? 8'h3F : 8'h40;
      op(1, 0, 8'h70, ix, 0, 0, 0);
      op(0, 1, 8'h71, 0, 0, 0, 0);
      op(1, 0, 8'h71, 8'h99, 0, 0, 0);
    end
    // R8 set, clear via F0 and F1, set+clear collision
    op(0, 0, 8'h00, 0, 0, 0, 1);
    op(1, 0, 8'hF0, 8'hA5, 0, 0, 0);
    op(0, 0, 8'h00, 0, 0, 0, 1);
    op(1, 0, 8'hF1, 8'h00, 0, 0, 1);
    op(1, 0, 8'hF1, 8'h33, 0, 0, 0);
    op(0, 0, 8'h00, 0, 0, 0, 0);
    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a, d;
      logic w;
      case ($urandom % 7)
        0: a = 8'h70; 1, 2: a = 8'h71; 3: a = 8'h92;
        4: a = 8'hF0; 5: a = 8'hF1; default: a = 8'($urandom);
      endcase
      d = 8'($urandom);
      if (a == 8'h70 && ($urandom % 2)) d = 8'h34 + 8'($urandom % 16);
      if (a == 8'h92 && ($urandom % 3) != 0) d[5] = 0;
      w = $urandom % 2;
      op(w, !w, a, d, ($urandom % 8) == 0, $urandom % 2, ($urandom % 6) == 0);
      if (n == 300) begin
        do_reset();
        op(0, 1, 8'h92, 0, 0, 0, 0);
      end
    end
    // R5 reset releases lock
    op(1, 0, 8'h92, 8'h20, 1, 0, 0);
    do_reset();
    op(0, 1, 8'h92, 0, 0, 0, 0);
    op(0, 0, 8'h00, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule